// File: doc/BRIEF.md
# Sleep and Wake-Up Controller

This block governs the low-power idle state of a small 8-bit processor core. When the core decodes its sleep instruction it raises a one-cycle strobe. The controller then decides whether the instruction really executes or degrades to a no-op. An executed sleep clears the watchdog, updates two status bits and stops the core oscillator until a wake event arrives.

Two events wake the core: a watchdog time-out, or any interrupt source whose own enable bit is set. The global interrupt enable has no say in whether the core wakes. It only decides whether the core takes the interrupt vector once the prefetched instruction after the sleep has retired. An external reset request is not a wake event. It returns the controller to its power-up state from any state.

The watchdog counter, the decoder, the program counter and the peripherals lie outside this block. The controller sees them only as strobes and levels.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After power-up reset the controller runs with osc_en=1, stat_pd=1, stat_to=1, and wdt_clr, resume_stb and vector_req all low.
- R2: A sleep_stb in the running state with no enabled interrupt pending executes the sleep. In the next cycle osc_en=0, stat_pd=0 and stat_to=1, and wdt_clr is high for exactly that one cycle.
- R3: A sleep_stb seen while some bit of irq_flag & irq_en is set is a no-op. In the next cycle osc_en stays 1, wdt_clr stays 0, and stat_pd and stat_to keep their values.
- R4: Interrupt source i (bit i of irq_flag and irq_en) counts as pending only when both bits are 1. A flag whose enable is 0 neither blocks a sleep nor wakes the core, whatever the value of gie.
- R5: While asleep, osc_en stays 0 until a wake event. In the cycle after the event osc_en returns to 1 and resume_stb is high for exactly one cycle, and the controller is then running.
- R6: A watchdog time-out that wakes the core sets stat_to to 0 in the cycle after the event.
- R7: A wake with gie=0 in the event cycle never raises vector_req.
- R8: A wake caused by an enabled interrupt with gie=1 in the event cycle raises vector_req for exactly one cycle. That cycle follows the first step_done after the wake, and vector_req never rises before it.
- R9: ext_rst_req, in any state, returns the controller in the next cycle to osc_en=1, stat_pd=1, stat_to=1 and resume_stb=0.
- R10: A clrwdt_stb in the running state raises wdt_clr for one cycle in the next cycle and leaves both status bits unchanged.
- R11: A sleep_stb while asleep is ignored: osc_en and stat_pd stay 0. A wdt_timeout while running does not change stat_to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| ext_rst_req | input | 1 | External reset request, synchronous, active high |
| sleep_stb | input | 1 | Sleep instruction decoded |
| clrwdt_stb | input | 1 | Clear-watchdog instruction decoded |
| irq_flag | input | NUM_SRC | Interrupt flags, one per source |
| irq_en | input | NUM_SRC | Interrupt enables, one per source |
| gie | input | 1 | Global interrupt enable |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| step_done | input | 1 | The core retired one instruction |
| osc_en | output | 1 | Oscillator run enable |
| wdt_clr | output | 1 | Clear watchdog and its postscaler |
| stat_pd | output | 1 | Power-down status, 0 after an executed sleep |
| stat_to | output | 1 | Time-out status, 0 after a watchdog wake |
| resume_stb | output | 1 | Execution resumes after a wake |
| vector_req | output | 1 | Branch to the interrupt vector |

## Verification
Two collisions are provoked on purpose. In the first, an interrupt that is enabled and pending arrives in the same cycle as the sleep strobe. The bench sweeps every combination of flag and enable on four sources and expects the sleep to execute exactly when the bitwise AND of flags and enables is zero. In the second, a watchdog time-out and an enabled interrupt wake the core in the same cycle. The bench then expects stat_to to fall and, with gie set, a vector request to follow the next retired instruction.

// File: rtl/slp_pkg.sv
package slp_pkg;
   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_SLEEP = 2'd1,
      ST_WAKE  = 2'd2
   } slp_state_t;
endpackage

// File: rtl/slp_wake_detect.sv
module slp_wake_detect #(
   parameter int NUM_SRC = 4
) (
   input  logic [NUM_SRC-1:0] flag,
   input  logic [NUM_SRC-1:0] en,
   output logic               pend_any
);
   localparam int LAST = NUM_SRC - 1;

   logic [LAST:0] hit;

   if (NUM_SRC < 1 || NUM_SRC > 32) begin : g_bad_cfg
      $error("slp_wake_detect: NUM_SRC must be within 1..32");
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign hit[i] = flag[i] & en[i];
   end

   assign pend_any = |hit;
endmodule

// File: rtl/slp_status_regs.sv
module slp_status_regs (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_rst,
   input  logic sleep_exec,
   input  logic wdt_wake,
   output logic stat_pd,
   output logic stat_to
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_pd <= 1'b1;
         stat_to <= 1'b1;
      end else if (ext_rst) begin
         stat_pd <= 1'b1;
         stat_to <= 1'b1;
      end else if (sleep_exec) begin
         stat_pd <= 1'b0;
         stat_to <= 1'b1;
      end else if (wdt_wake) begin
         stat_to <= 1'b0;
      end
   end

   // R6: a watchdog wake drops the time-out bit
   p_to_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_wake && !ext_rst) |=> !stat_to);
   // R2: an executed sleep clears power-down and sets time-out
   p_pd_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_exec && !ext_rst) |=> (!stat_pd && stat_to));
endmodule

// File: rtl/slp_vector_track.sv
module slp_vector_track (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_rst,
   input  logic wake_evt,
   input  logic irq_wake,
   input  logic gie,
   input  logic running,
   input  logic step_done,
   output logic vector_req
);
   logic vec_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_pend   <= 1'b0;
         vector_req <= 1'b0;
      end else if (ext_rst) begin
         vec_pend   <= 1'b0;
         vector_req <= 1'b0;
      end else begin
         vector_req <= 1'b0;
         if (wake_evt) begin
            vec_pend <= gie & irq_wake;
         end else if (vec_pend && running && step_done) begin
            vec_pend   <= 1'b0;
            vector_req <= 1'b1;
         end
      end
   end

   // R8: the vector request is a single-cycle pulse
   p_vec_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      vector_req |=> !vector_req);
   // R7: a wake with the global enable clear never leads to a vector
   p_no_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_evt && !gie && !ext_rst) |=> !vec_pend);
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
   import slp_pkg::*;
#(
   parameter int NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ext_rst_req,
   input  logic               sleep_stb,
   input  logic               clrwdt_stb,
   input  logic [NUM_SRC-1:0] irq_flag,
   input  logic [NUM_SRC-1:0] irq_en,
   input  logic               gie,
   input  logic               wdt_timeout,
   input  logic               step_done,
   output logic               osc_en,
   output logic               wdt_clr,
   output logic               stat_pd,
   output logic               stat_to,
   output logic               resume_stb,
   output logic               vector_req
);
   slp_state_t state, state_nx;
   logic       pend_any;
   logic       in_run;
   logic       sleep_exec;
   logic       wake_evt;
   logic       wdt_wake;

   slp_wake_detect #(.NUM_SRC(NUM_SRC)) u_detect (
      .flag     (irq_flag),
      .en       (irq_en),
      .pend_any (pend_any)
   );

   assign in_run     = (state == ST_RUN);
   assign sleep_exec = in_run && sleep_stb && !pend_any && !ext_rst_req;
   assign wake_evt   = (state == ST_SLEEP) && (pend_any || wdt_timeout) && !ext_rst_req;
   assign wdt_wake   = wake_evt && wdt_timeout;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_RUN:   if (sleep_exec) state_nx = ST_SLEEP;
         ST_SLEEP: if (wake_evt)   state_nx = ST_WAKE;
         ST_WAKE:  state_nx = ST_RUN;
         default:  state_nx = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_RUN;
         wdt_clr <= 1'b0;
      end else if (ext_rst_req) begin
         state   <= ST_RUN;
         wdt_clr <= 1'b0;
      end else begin
         state   <= state_nx;
         wdt_clr <= in_run && (clrwdt_stb || sleep_exec);
      end
   end

   assign osc_en     = (state != ST_SLEEP);
   assign resume_stb = (state == ST_WAKE);

   slp_status_regs u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_rst    (ext_rst_req),
      .sleep_exec (sleep_exec),
      .wdt_wake   (wdt_wake),
      .stat_pd    (stat_pd),
      .stat_to    (stat_to)
   );

   slp_vector_track u_vector (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_rst    (ext_rst_req),
      .wake_evt   (wake_evt),
      .irq_wake   (pend_any),
      .gie        (gie),
      .running    (in_run),
      .step_done  (step_done),
      .vector_req (vector_req)
   );

   // R2: executed sleep stops the clock and clears the watchdog
   p_sleep_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_run && sleep_stb && !pend_any && !ext_rst_req) |=> (!osc_en && wdt_clr));
   // R3: a pending enabled interrupt makes the sleep a no-op
   p_sleep_noop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_run && sleep_stb && pend_any && !ext_rst_req && !clrwdt_stb)
         |=> (osc_en && !wdt_clr && $stable(stat_pd) && $stable(stat_to)));
   // R5: wake event restores the clock with a resume pulse
   p_wake_osc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wake_evt |=> (osc_en && resume_stb));
   p_resume_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      resume_stb |=> !resume_stb);
   // R9: external reset restores the power-up state
   p_ext_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rst_req |=> (osc_en && stat_pd && stat_to && !resume_stb));
   // R11: sleep strobe while asleep does not resume the clock
   p_sleep_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_en && !pend_any && !wdt_timeout && !ext_rst_req) |=> !osc_en);
endmodule

// File: tb/sleep_wake_ctrl_tb.sv
module sleep_wake_ctrl_tb;
   localparam int NSRC = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ext_rst_req = 1'b0;
   logic            sleep_stb = 1'b0;
   logic            clrwdt_stb = 1'b0;
   logic [NSRC-1:0] irq_flag = '0;
   logic [NSRC-1:0] irq_en = '0;
   logic            gie = 1'b0;
   logic            wdt_timeout = 1'b0;
   logic            step_done = 1'b0;
   logic            osc_en, wdt_clr, stat_pd, stat_to, resume_stb, vector_req;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   sleep_wake_ctrl #(.NUM_SRC(NSRC)) u_dut (
      .clk(clk), .rst_n(rst_n), .ext_rst_req(ext_rst_req), .sleep_stb(sleep_stb),
      .clrwdt_stb(clrwdt_stb), .irq_flag(irq_flag), .irq_en(irq_en), .gie(gie),
      .wdt_timeout(wdt_timeout), .step_done(step_done), .osc_en(osc_en),
      .wdt_clr(wdt_clr), .stat_pd(stat_pd), .stat_to(stat_to),
      .resume_stb(resume_stb), .vector_req(vector_req)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_ext_reset();
      ext_rst_req = 1'b1;
      tick();
      ext_rst_req = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #1;
      tick();
      tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 osc_en", osc_en, 1);
      chk("R1 stat_pd", stat_pd, 1);
      chk("R1 stat_to", stat_to, 1);
      chk("R1 quiet outputs", {wdt_clr, resume_stb, vector_req}, 0);

      // R10 clear-watchdog in run
      clrwdt_stb = 1'b1;
      tick();
      clrwdt_stb = 1'b0;
      chk("R10 wdt_clr", wdt_clr, 1);
      chk("R10 status", {stat_pd, stat_to}, 3);
      tick();
      chk("R10 wdt_clr one cycle", wdt_clr, 0);

      // R11 watchdog time-out while running leaves stat_to alone
      wdt_timeout = 1'b1;
      tick();
      wdt_timeout = 1'b0;
      chk("R11 stat_to in run", stat_to, 1);
      chk("R11 osc_en in run", osc_en, 1);

      // R3/R4 sweep: sleep executes exactly when flags & enables == 0
      for (int f = 0; f < 16; f++) begin
         for (int e = 0; e < 16; e++) begin
            do_ext_reset();
            irq_flag = f[NSRC-1:0];
            irq_en = e[NSRC-1:0];
            gie = f[0] ^ e[1];
            sleep_stb = 1'b1;
            tick();
            sleep_stb = 1'b0;
            begin
               automatic logic ex = ((f & e) == 0);
               chk(ex ? "R4 sleep osc_en" : "R3 noop osc_en", osc_en, !ex);
               chk(ex ? "R4 sleep stat_pd" : "R3 noop stat_pd", stat_pd, !ex);
               chk(ex ? "R2 sleep wdt_clr" : "R3 noop wdt_clr", wdt_clr, ex);
            end
         end
      end
      irq_flag = '0;
      irq_en = '0;

      // Wake sweep: source, global enable, wake cause (bit0 irq, bit1 watchdog)
      for (int s = 0; s < NSRC; s++) begin
         for (int g = 0; g < 2; g++) begin
            for (int m = 1; m < 4; m++) begin
               do_ext_reset();
               irq_flag = '0;
               irq_en = NSRC'(1 << s);
               gie = g[0];
               sleep_stb = 1'b1;
               tick();
               sleep_stb = 1'b0;
               chk("R2 osc_en", osc_en, 0);
               chk("R2 stat_pd", stat_pd, 0);
               chk("R2 stat_to", stat_to, 1);
               chk("R2 wdt_clr", wdt_clr, 1);
               // R11 second sleep strobe while asleep
               sleep_stb = 1'b1;
               tick();
               sleep_stb = 1'b0;
               chk("R2 wdt_clr one cycle", wdt_clr, 0);
               chk("R11 asleep osc_en", osc_en, 0);
               chk("R11 asleep stat_pd", stat_pd, 0);
               // R4 disabled flags do not wake
               irq_flag = NSRC'(~(1 << s));
               tick();
               tick();
               chk("R4 masked flags osc_en", osc_en, 0);
               chk("R5 no resume while asleep", resume_stb, 0);
               irq_flag = irq_flag | NSRC'(m[0] << s);
               wdt_timeout = m[1];
               tick();
               irq_flag = '0;
               wdt_timeout = 1'b0;
               chk("R5 osc_en after wake", osc_en, 1);
               chk("R5 resume_stb", resume_stb, 1);
               chk("R6 stat_to", stat_to, !m[1]);
               chk("R2 stat_pd kept", stat_pd, 0);
               tick();
               chk("R5 resume one cycle", resume_stb, 0);
               chk("R5 running", osc_en, 1);
               chk("R8 no early vector", vector_req, 0);
               step_done = 1'b1;
               tick();
               step_done = 1'b0;
               if (g == 1 && m[0])
                  chk("R8 vector_req", vector_req, 1);
               else
                  chk("R7 vector_req", vector_req, 0);
               tick();
               chk("R8 vector one cycle", vector_req, 0);
            end
         end
      end

      // R9 external reset while asleep
      do_ext_reset();
      irq_en = '0;
      gie = 1'b1;
      sleep_stb = 1'b1;
      tick();
      sleep_stb = 1'b0;
      chk("R9 asleep before reset", osc_en, 0);
      ext_rst_req = 1'b1;
      tick();
      ext_rst_req = 1'b0;
      chk("R9 osc_en", osc_en, 1);
      chk("R9 status", {stat_pd, stat_to}, 3);
      chk("R9 resume_stb", resume_stb, 0);
      tick();
      chk("R9 stays running", {osc_en, resume_stb}, 2);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule